// File: doc/BRIEF.md
# AXI4 Burst Memory Self-Test Master

This block is a closed self-test engine for a memory that sits behind an AXI4 slave port. One start pulse makes it check that a base address is legal. It then writes a single 8-beat incrementing burst of 32-bit words and reads the same burst back. Every returned beat is compared against the word that was written. When the test ends, it leaves a result on its status outputs: done, pass, the number of beats that did not match, and the index of the first beat that did not match.

The test word alternates between two values. The lower halfword is 0xA5A5 on even beats and 0x5A5A on odd beats. The upper halfword is always the bitwise complement of the lower one, so every data lane toggles in both directions. The block allows only one transaction in flight. Its phases run one after another: write address, write data, write response, read address, read data. Because the read address is not issued until the write response has been accepted, the readback sees the data just written. If a slave folds several beats onto the same address, several beats return identical words. The block reports this as a mismatch.

Top module: `memtest_axi_master`

## Requirements
- R1: After reset, done, pass and addr_err are 0, and every AXI valid and ready output of the block is 0.
- R2: A start with a legal base issues a write address equal to the base, with length code 7 (8 beats), size code 2 (4 bytes per beat) and burst code 1 (incrementing).
- R3: While a VALID is high without its READY, the block holds that VALID and keeps its address (AW, AR) or its data and last flag (W) unchanged.
- R4: Write beat i carries 0x5A5AA5A5 when i is even and 0xA5A55A5A when i is odd, beat 0 first. WLAST is high only on beat 7.
- R5: The read address, with the same base, length, size and burst codes as the write, is issued only after the write response handshake.
- R6: Each read beat is compared in order with the word written at that index. mismatch_cnt holds the number of differing beats, first_fail_idx holds the lowest such index, and pass is 1 only if no beat differs.
- R7: A read beat whose response code is not 0 (OKAY) counts as a mismatch at its index.
- R8: A write response code other than 0 (OKAY) clears pass, but the readback still runs to the end.
- R9: If RLAST arrives on any beat other than beat 7, or is missing on beat 7, pass is 0. The read phase ends only when RLAST is accepted.
- R10: A base is illegal if it is not 4-byte aligned, if any of its 32 bytes lie outside 0x1000_0000..0x1FFF_FFFF, or if the burst crosses a 4 KB boundary (base[11:0] > 0xFE0). An illegal base sets done and addr_err, leaves pass at 0, and issues no transaction.
- R11: done, pass and the counts hold their values until the next accepted start. A start pulse while a test is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that starts a test when idle |
| base_addr | input | 32 | Byte address of the burst under test |
| done | output | 1 | High once the test or address rejection has finished |
| pass | output | 1 | High when the test finished with no error |
| addr_err | output | 1 | High when the base was rejected |
| mismatch_cnt | output | 4 | Number of read beats that differed |
| first_fail_idx | output | 3 | Index of the lowest differing beat |
| m_awaddr | output | 32 | Write address |
| m_awlen | output | 8 | Write burst length code |
| m_awsize | output | 3 | Write beat size code |
| m_awburst | output | 2 | Write burst type |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Write byte strobes, all ones |
| m_wlast | output | 1 | Last write beat |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | 32 | Read address |
| m_arlen | output | 8 | Read burst length code |
| m_arsize | output | 3 | Read beat size code |
| m_arburst | output | 2 | Read burst type |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | 32 | Read data |
| m_rresp | input | 2 | Read response code |
| m_rlast | input | 1 | Last read beat |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
Some rules are checked by assertions on every cycle: VALID and payload hold under back-pressure, WLAST sits on the eighth counted write beat, the read address only starts after a write-response handshake, an address rejection always reads as done without pass, and a finished block has no channel active. Other behaviour can only be shown by the bench scenarios, because it depends on what the memory returns. This covers the exact data pattern and addresses, the mismatch count and first index for a corrupted beat, for aliased addresses and for an error response, the handling of a misplaced RLAST, and the boundary addresses of the legality rule.

// File: rtl/memtest_pkg.sv
package memtest_pkg;
  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam logic [1:0] BURST_INCR = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AW,
    ST_W,
    ST_B,
    ST_AR,
    ST_R,
    ST_FIN
  } mt_state_e;
endpackage

// File: rtl/memtest_pattern.sv
module memtest_pattern #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W/2-1:0] PAT_EVEN = 16'hA5A5,
  parameter logic [DATA_W/2-1:0] PAT_ODD  = 16'h5A5A
) (
  input  logic              beat_odd,
  output logic [DATA_W-1:0] word
);
  localparam int HALF = DATA_W / 2;

  logic [HALF-1:0] lo;

  // low half alternates, high half is its complement
  assign lo   = beat_odd ? PAT_ODD : PAT_EVEN;
  assign word = {~lo, lo};
endmodule

// File: rtl/memtest_addr_check.sv
module memtest_addr_check #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 8,
  parameter logic [ADDR_W-1:0] WIN_LO = 32'h1000_0000,
  parameter logic [ADDR_W-1:0] WIN_HI = 32'h1FFF_FFFF
) (
  input  logic [ADDR_W-1:0] base,
  output logic              legal
);
  localparam int STRB_W      = DATA_W / 8;
  localparam int ALIGN_W     = $clog2(STRB_W);
  localparam int BURST_BYTES = BEATS * STRB_W;
  localparam logic [11:0] PAGE_LIMIT = 12'(4096 - BURST_BYTES);

  logic          aligned;
  logic          above_lo;
  logic          below_hi;
  logic          in_page;
  logic [ADDR_W:0] burst_end;

  assign burst_end = {1'b0, base} + (ADDR_W+1)'(BURST_BYTES - 1);
  assign aligned   = (base[ALIGN_W-1:0] == '0);
  assign above_lo  = (base >= WIN_LO);
  assign below_hi  = (burst_end <= {1'b0, WIN_HI});
  assign in_page   = (base[11:0] <= PAGE_LIMIT);
  assign legal     = aligned && above_lo && below_hi && in_page;
endmodule

// File: rtl/memtest_rd_check.sv
module memtest_rd_check
  import memtest_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BEATS  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       beat_vld,
  input  logic [DATA_W-1:0]          rdata,
  input  logic [1:0]                 rresp,
  input  logic                       rlast,
  output logic [$clog2(BEATS+1)-1:0] err_cnt,
  output logic [$clog2(BEATS)-1:0]   first_idx,
  output logic                       frame_err
);
  localparam int IDX_W = $clog2(BEATS);
  localparam int CNT_W = $clog2(BEATS+1);

  logic [CNT_W-1:0]  idx;
  logic [DATA_W-1:0] expect_word;
  logic              in_burst;
  logic              beat_bad;
  logic              last_due;

  memtest_pattern #(.DATA_W(DATA_W)) u_exp (
    .beat_odd (idx[0]),
    .word     (expect_word)
  );

  assign in_burst = (idx < CNT_W'(BEATS));
  assign last_due = (idx == CNT_W'(BEATS - 1));
  assign beat_bad = (rdata != expect_word) || (rresp != RESP_OKAY);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx       <= '0;
      err_cnt   <= '0;
      first_idx <= '0;
      frame_err <= 1'b0;
    end else if (beat_vld) begin
      if (in_burst) begin
        idx <= idx + 1'b1;
        if (beat_bad) begin
          err_cnt <= err_cnt + 1'b1;
          if (err_cnt == '0) first_idx <= idx[IDX_W-1:0];
        end
        if (rlast != last_due) frame_err <= 1'b1;
      end else begin
        // beat beyond the requested length
        frame_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/memtest_axi_master.sv
module memtest_axi_master
  import memtest_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 8,
  parameter logic [ADDR_W-1:0] WIN_LO = 32'h1000_0000,
  parameter logic [ADDR_W-1:0] WIN_HI = 32'h1FFF_FFFF
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [ADDR_W-1:0]          base_addr,
  output logic                       done,
  output logic                       pass,
  output logic                       addr_err,
  output logic [$clog2(BEATS+1)-1:0] mismatch_cnt,
  output logic [$clog2(BEATS)-1:0]   first_fail_idx,
  output logic [ADDR_W-1:0]          m_awaddr,
  output logic [7:0]                 m_awlen,
  output logic [2:0]                 m_awsize,
  output logic [1:0]                 m_awburst,
  output logic                       m_awvalid,
  input  logic                       m_awready,
  output logic [DATA_W-1:0]          m_wdata,
  output logic [DATA_W/8-1:0]        m_wstrb,
  output logic                       m_wlast,
  output logic                       m_wvalid,
  input  logic                       m_wready,
  input  logic [1:0]                 m_bresp,
  input  logic                       m_bvalid,
  output logic                       m_bready,
  output logic [ADDR_W-1:0]          m_araddr,
  output logic [7:0]                 m_arlen,
  output logic [2:0]                 m_arsize,
  output logic [1:0]                 m_arburst,
  output logic                       m_arvalid,
  input  logic                       m_arready,
  input  logic [DATA_W-1:0]          m_rdata,
  input  logic [1:0]                 m_rresp,
  input  logic                       m_rlast,
  input  logic                       m_rvalid,
  output logic                       m_rready
);
  localparam int STRB_W    = DATA_W / 8;
  localparam int IDX_W     = $clog2(BEATS);
  localparam int CNT_W     = $clog2(BEATS+1);
  localparam int SIZE_CODE = $clog2(STRB_W);

  mt_state_e         state;
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  wbeat;
  logic              awvalid_q, wvalid_q, wlast_q, bready_q, arvalid_q, rready_q;
  logic              bfail_q, done_q, pass_q, addr_err_q;
  logic              base_legal;
  logic              launch;
  logic              rbeat_vld;
  logic [CNT_W-1:0]  err_cnt;
  logic [IDX_W-1:0]  first_idx;
  logic              frame_err;

  memtest_addr_check #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BEATS  (BEATS),
    .WIN_LO (WIN_LO),
    .WIN_HI (WIN_HI)
  ) u_addr (
    .base  (base_addr),
    .legal (base_legal)
  );

  memtest_pattern #(.DATA_W(DATA_W)) u_wpat (
    .beat_odd (wbeat[0]),
    .word     (m_wdata)
  );

  assign launch    = (state == ST_IDLE) && start && base_legal;
  assign rbeat_vld = m_rvalid && rready_q;

  memtest_rd_check #(
    .DATA_W (DATA_W),
    .BEATS  (BEATS)
  ) u_rchk (
    .clk       (clk),
    .rst       (rst),
    .clr       (launch),
    .beat_vld  (rbeat_vld),
    .rdata     (m_rdata),
    .rresp     (m_rresp),
    .rlast     (m_rlast),
    .err_cnt   (err_cnt),
    .first_idx (first_idx),
    .frame_err (frame_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      base_q     <= '0;
      wbeat      <= '0;
      awvalid_q  <= 1'b0;
      wvalid_q   <= 1'b0;
      wlast_q    <= 1'b0;
      bready_q   <= 1'b0;
      arvalid_q  <= 1'b0;
      rready_q   <= 1'b0;
      bfail_q    <= 1'b0;
      done_q     <= 1'b0;
      pass_q     <= 1'b0;
      addr_err_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            pass_q <= 1'b0;
            if (base_legal) begin
              done_q     <= 1'b0;
              addr_err_q <= 1'b0;
              bfail_q    <= 1'b0;
              base_q     <= base_addr;
              awvalid_q  <= 1'b1;
              state      <= ST_AW;
            end else begin
              done_q     <= 1'b1;
              addr_err_q <= 1'b1;
            end
          end
        end
        ST_AW: begin
          if (m_awready) begin
            awvalid_q <= 1'b0;
            wvalid_q  <= 1'b1;
            wbeat     <= '0;
            wlast_q   <= (BEATS == 1);
            state     <= ST_W;
          end
        end
        ST_W: begin
          if (m_wready) begin
            if (wlast_q) begin
              wvalid_q <= 1'b0;
              wlast_q  <= 1'b0;
              bready_q <= 1'b1;
              state    <= ST_B;
            end else begin
              wbeat   <= wbeat + 1'b1;
              wlast_q <= (wbeat == IDX_W'(BEATS - 2));
            end
          end
        end
        ST_B: begin
          if (m_bvalid) begin
            bready_q  <= 1'b0;
            bfail_q   <= (m_bresp != RESP_OKAY);
            arvalid_q <= 1'b1;
            state     <= ST_AR;
          end
        end
        ST_AR: begin
          if (m_arready) begin
            arvalid_q <= 1'b0;
            rready_q  <= 1'b1;
            state     <= ST_R;
          end
        end
        ST_R: begin
          if (m_rvalid && m_rlast) begin
            rready_q <= 1'b0;
            state    <= ST_FIN;
          end
        end
        ST_FIN: begin
          done_q <= 1'b1;
          pass_q <= !bfail_q && !frame_err && (err_cnt == '0);
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done           = done_q;
  assign pass           = pass_q;
  assign addr_err       = addr_err_q;
  assign mismatch_cnt   = err_cnt;
  assign first_fail_idx = first_idx;

  assign m_awaddr  = base_q;
  assign m_awlen   = 8'(BEATS - 1);
  assign m_awsize  = 3'(SIZE_CODE);
  assign m_awburst = BURST_INCR;
  assign m_awvalid = awvalid_q;
  assign m_wstrb   = '1;
  assign m_wlast   = wlast_q;
  assign m_wvalid  = wvalid_q;
  assign m_bready  = bready_q;
  assign m_araddr  = base_q;
  assign m_arlen   = 8'(BEATS - 1);
  assign m_arsize  = 3'(SIZE_CODE);
  assign m_arburst = BURST_INCR;
  assign m_arvalid = arvalid_q;
  assign m_rready  = rready_q;
endmodule

// File: rtl/memtest_axi_master_chk.sv
module memtest_axi_master_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              pass,
  input logic              addr_err,
  input logic [ADDR_W-1:0] m_awaddr,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic [DATA_W-1:0] m_wdata,
  input logic              m_wlast,
  input logic              m_wvalid,
  input logic              m_wready,
  input logic              m_bvalid,
  input logic              m_bready,
  input logic [ADDR_W-1:0] m_araddr,
  input logic              m_arvalid,
  input logic              m_arready,
  input logic              m_rready
);
  localparam int WC_W = $clog2(BEATS + 1);

  logic [WC_W-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst || (m_awvalid && m_awready)) wcnt <= '0;
    else if (m_wvalid && m_wready)       wcnt <= wcnt + 1'b1;
  end

  // R3
  aw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr));

  // R3
  w_hold_chk: assert property (@(posedge clk) disable iff (rst)
    m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata) && $stable(m_wlast));

  // R3
  ar_hold_chk: assert property (@(posedge clk) disable iff (rst)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr));

  // R4
  wlast_pos_chk: assert property (@(posedge clk) disable iff (rst)
    m_wvalid && m_wlast |-> wcnt == WC_W'(BEATS - 1));

  // R5
  ar_after_b_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(m_arvalid) |-> $past(m_bvalid && m_bready));

  // R10
  addr_err_chk: assert property (@(posedge clk) disable iff (rst)
    addr_err |-> done && !pass);

  // R11
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !m_awvalid && !m_wvalid && !m_arvalid && !m_rready);
endmodule

bind memtest_axi_master memtest_axi_master_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .BEATS  (BEATS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .done      (done),
  .pass      (pass),
  .addr_err  (addr_err),
  .m_awaddr  (m_awaddr),
  .m_awvalid (m_awvalid),
  .m_awready (m_awready),
  .m_wdata   (m_wdata),
  .m_wlast   (m_wlast),
  .m_wvalid  (m_wvalid),
  .m_wready  (m_wready),
  .m_bvalid  (m_bvalid),
  .m_bready  (m_bready),
  .m_araddr  (m_araddr),
  .m_arvalid (m_arvalid),
  .m_arready (m_arready),
  .m_rready  (m_rready)
);

// File: tb/memtest_axi_master_test.sv
module memtest_axi_master_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic        done, pass, addr_err;
  logic [3:0]  mismatch_cnt;
  logic [2:0]  first_fail_idx;
  logic [31:0] m_awaddr, m_araddr, m_wdata, m_rdata;
  logic [7:0]  m_awlen, m_arlen;
  logic [2:0]  m_awsize, m_arsize;
  logic [1:0]  m_awburst, m_arburst, m_bresp, m_rresp;
  logic [3:0]  m_wstrb;
  logic        m_awvalid, m_awready, m_wlast, m_wvalid, m_wready;
  logic        m_bvalid, m_bready, m_arvalid, m_arready;
  logic        m_rlast, m_rvalid, m_rready;

  always #5 clk = ~clk;

  memtest_axi_master uut (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .done(done), .pass(pass), .addr_err(addr_err),
    .mismatch_cnt(mismatch_cnt), .first_fail_idx(first_fail_idx),
    .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize),
    .m_awburst(m_awburst), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast),
    .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize),
    .m_arburst(m_arburst), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rlast(m_rlast),
    .m_rvalid(m_rvalid), .m_rready(m_rready)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    return (i % 2 == 1) ? 32'hA5A5_5A5A : 32'h5A5A_A5A5;
  endfunction

  // ---------------- memory slave model ----------------
  // fault modes: 0 none, 1 corrupt beat, 2 aliased groups of four,
  // 3 error response on a beat, 4 write response error, 5 early last, 6 late last
  int          fault_mode = 0;
  int          fault_beat = 0;
  bit          stall = 1'b0;
  logic [7:0]  tick;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] s_waddr, s_raddr;
  int          s_rcnt;
  logic        rd_act;

  always @(posedge clk) begin
    if (rst) tick <= '0;
    else     tick <= tick + 1'b1;
  end

  assign m_awready = !stall || tick[0];
  assign m_wready  = !stall || tick[1];
  assign m_arready = !stall || tick[0];
  assign m_rvalid  = rd_act && (!stall || tick[1]);
  assign m_rlast   = (fault_mode == 5) ? (s_rcnt == fault_beat) :
                     (fault_mode == 6) ? (s_rcnt == 8) : (s_rcnt == 7);
  assign m_rresp   = (fault_mode == 3 && s_rcnt == fault_beat) ? 2'b10 : 2'b00;

  always_comb begin
    logic [31:0] eff;
    eff = (fault_mode == 2) ? s_raddr + 32'(4 * (s_rcnt | 3)) : s_raddr + 32'(4 * s_rcnt);
    m_rdata = mem.exists(eff) ? mem[eff] : 32'h0;
    if (fault_mode == 1 && s_rcnt == fault_beat) m_rdata = m_rdata ^ 32'h0000_0100;
  end

  always @(posedge clk) begin
    if (rst) begin
      m_bvalid <= 1'b0;
      m_bresp  <= 2'b00;
      rd_act   <= 1'b0;
      s_rcnt   <= 0;
    end else begin
      if (m_awvalid && m_awready) s_waddr <= m_awaddr;
      if (m_wvalid && m_wready) begin
        mem[s_waddr] = m_wdata;
        s_waddr <= s_waddr + 32'd4;
        if (m_wlast) begin
          m_bvalid <= 1'b1;
          m_bresp  <= (fault_mode == 4) ? 2'b10 : 2'b00;
        end
      end
      if (m_bvalid && m_bready) m_bvalid <= 1'b0;
      if (m_arvalid && m_arready) begin
        s_raddr <= m_araddr;
        s_rcnt  <= 0;
        rd_act  <= 1'b1;
      end
      if (m_rvalid && m_rready) begin
        s_rcnt <= s_rcnt + 1;
        if (m_rlast) rd_act <= 1'b0;
      end
    end
  end

  // ---------------- scoreboard monitor ----------------
  logic [63:0] exp_q [$];
  logic [31:0] cur_base;
  logic [31:0] mon_waddr;
  int          aw_count = 0;
  bit          b_seen = 1'b0;
  bit          aw_pend = 1'b0, w_pend = 1'b0;
  logic [31:0] aw_prev, w_prev;

  always @(negedge clk) begin
    if (!rst) begin
      // R3 hold under back-pressure
      if (aw_pend) chk(m_awvalid && m_awaddr == aw_prev, "R3 awaddr hold", m_awaddr, aw_prev);
      if (w_pend)  chk(m_wvalid && m_wdata == w_prev, "R3 wdata hold", m_wdata, w_prev);
      aw_pend = m_awvalid && !m_awready;
      aw_prev = m_awaddr;
      w_pend  = m_wvalid && !m_wready;
      w_prev  = m_wdata;
      if (m_awvalid && m_awready) begin
        aw_count++;
        b_seen = 1'b0;
        mon_waddr = m_awaddr;
        chk(m_awaddr == cur_base, "R2 awaddr", m_awaddr, cur_base);
        chk({m_awlen, m_awsize, m_awburst} == {8'd7, 3'd2, 2'd1}, "R2 aw ctrl",
            32'({m_awlen, m_awsize, m_awburst}), 32'({8'd7, 3'd2, 2'd1}));
      end
      if (m_wvalid && m_wready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected write beat", m_wdata, 32'h0);
        end else begin
          logic [63:0] item;
          item = exp_q.pop_front();
          chk(m_wdata == item[31:0], "R4 wdata", m_wdata, item[31:0]);
          chk(mon_waddr == item[63:32], "R4 beat addr", mon_waddr, item[63:32]);
          chk(m_wlast == (exp_q.size() == 0), "R4 wlast", 32'(m_wlast), 32'(exp_q.size() == 0));
          mon_waddr = mon_waddr + 32'd4;
        end
      end
      if (m_bvalid && m_bready) b_seen = 1'b1;
      if (m_arvalid && m_arready) begin
        chk(b_seen, "R5 ar after b", 32'(b_seen), 32'd1);
        chk(m_araddr == cur_base, "R5 araddr", m_araddr, cur_base);
        chk({m_arlen, m_arsize, m_arburst} == {8'd7, 3'd2, 2'd1}, "R5 ar ctrl",
            32'({m_arlen, m_arsize, m_arburst}), 32'({8'd7, 3'd2, 2'd1}));
      end
    end
  end

  // ---------------- driver ----------------
  task automatic run(input logic [31:0] base, input bit legal, input bit exp_pass,
                     input int exp_cnt, input int exp_first, input bit mid_start,
                     input string req);
    int t;
    mem.delete();
    cur_base = base;
    aw_count = 0;
    if (legal) for (int i = 0; i < 8; i++) exp_q.push_back({base + 32'(4 * i), pat(i)});
    @(negedge clk);
    base_addr = base;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mid_start) begin
      repeat (3) @(negedge clk);
      base_addr = 32'h1000_0002;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(done, {req, " done"}, 32'(done), 32'd1);
    chk(addr_err == !legal, {req, " addr_err"}, 32'(addr_err), 32'(!legal));
    chk(pass == exp_pass, {req, " pass"}, 32'(pass), 32'(exp_pass));
    chk(mismatch_cnt == 4'(exp_cnt), {req, " mismatch_cnt"}, 32'(mismatch_cnt), 32'(exp_cnt));
    if (exp_cnt > 0)
      chk(first_fail_idx == 3'(exp_first), {req, " first_fail_idx"}, 32'(first_fail_idx), 32'(exp_first));
    chk(aw_count == (legal ? 1 : 0), {req, " aw count"}, 32'(aw_count), 32'(legal ? 1 : 0));
    chk(exp_q.size() == 0, {req, " writes left"}, 32'(exp_q.size()), 32'd0);
    chk(!m_awvalid && !m_arvalid && !m_wvalid, {req, " bus quiet"}, 32'({m_awvalid, m_wvalid, m_arvalid}), 32'd0);
    exp_q.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({done, pass, addr_err} == 3'b000, "R1 status", 32'({done, pass, addr_err}), 32'd0);
    chk({m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready} == 5'b0, "R1 channels",
        32'({m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready}), 32'd0);

    // R2 R4 R5 R6 clean pass
    run(32'h1000_0000, 1, 1, 0, 0, 0, "R6 clean");
    // R3 back-pressure on every channel
    stall = 1'b1;
    run(32'h1234_5F00, 1, 1, 0, 0, 0, "R3 stalled");
    stall = 1'b0;
    // R6 single corrupted beat
    fault_mode = 1; fault_beat = 5;
    run(32'h1000_0100, 1, 0, 1, 5, 0, "R6 corrupt");
    // R6 aliased address groups return repeated words
    fault_mode = 2;
    run(32'h1000_0200, 1, 0, 4, 0, 0, "R6 alias");
    // R7 error response on one read beat
    fault_mode = 3; fault_beat = 2;
    run(32'h1000_0300, 1, 0, 1, 2, 0, "R7 rresp");
    // R8 write response error
    fault_mode = 4;
    run(32'h1000_0400, 1, 0, 0, 0, 0, "R8 bresp");
    // R9 early and late RLAST
    fault_mode = 5; fault_beat = 5;
    run(32'h1000_0500, 1, 0, 0, 0, 0, "R9 early last");
    fault_mode = 6;
    run(32'h1000_0600, 1, 0, 0, 0, 0, "R9 late last");
    fault_mode = 0;
    // R10 illegal and boundary bases
    run(32'h1000_0002, 0, 0, 0, 0, 0, "R10 unaligned");
    run(32'h0FFF_F000, 0, 0, 0, 0, 0, "R10 below");
    run(32'h2000_0000, 0, 0, 0, 0, 0, "R10 above");
    run(32'h1000_0FE4, 0, 0, 0, 0, 0, "R10 page cross");
    run(32'h1000_0FE0, 1, 1, 0, 0, 0, "R10 page edge");
    run(32'h1FFF_FFE0, 1, 1, 0, 0, 0, "R10 window end");
    // R11 start while busy ignored, result sticky
    run(32'h1000_0700, 1, 1, 0, 0, 1, "R11 busy start");
    repeat (5) @(negedge clk);
    chk(done && pass && !addr_err, "R11 sticky", 32'({done, pass, addr_err}), 32'b110);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule